// File: doc/BRIEF.md
# Three-Channel Compare PWM Stage with Dead-Time Insertion

This block turns a free-running count from an external general-purpose timer into six PWM pin drives. Three compare channels each compare the shared timer count against their own compare value and produce one raw waveform. Each raw waveform is split into a complementary high-side/low-side pair. When dead-time insertion is on for that channel, both members of the pair are held off for a programmable time after every raw transition, so the two switches of a half bridge are never on together.

Compare values and the per-pin output actions are written into shadow registers. They move into the active registers only on the clock edge where the timer count is zero, so a pulse width or polarity change always begins with a new period. The dead time comes from one shared 8-bit value and is counted by a separate counter in each channel. That counter advances on a prescaled enable, which lets short values span long delays. A global enable forces all pins low.

Top module: `pwm3_db_stage`

## Requirements
- R1: A channel's raw signal is high when the timer count is strictly less than its active compare value. Pin 2c is the high side of channel c and follows the raw signal. Pin 2c+1 is the low side and carries its complement. A timer count change reaches the pins on the second rising clock edge after it is applied.
- R2: A compare write changes only the shadow copy. The shadow becomes active on the edge where the timer count is 0, and the raw signal sampled at that edge already uses the new value.
- R3: Each pin p has a 2-bit action code at bits [2p+1:2p] of the action word: 00 drives low, 01 drives the inverted pair signal, 10 drives the pair signal, 11 drives high.
- R4: An action-word write has no effect on the pins until an edge where the timer count is 0.
- R5: With dead time enabled and the prescaler at 1 (select 0), each raw transition is followed by exactly D+1 consecutive cycles in which both pins of the pair are low, D being the dead-time value.
- R6: With dead time disabled for a channel, the two pins switch in the same cycle with no cycle in which both are low.
- R7: A raw transition that arrives while dead time is still running restarts the count, and both pins stay low until D+1 cycles after the latest transition.
- R8: With divider select s (period P = 2^s), the both-low window after a transition lasts between (D-1)*P+2 and D*P+1 cycles for D >= 1.
- R9: While the output enable is low, all six pins are low from the next rising edge on. Pins resume normal drive one edge after it returns high.
- R10: Synchronous reset clears all shadow and active registers. All pins read low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | 16 | Count of the external time-base timer |
| cmp_wr_en | input | 3 | Per-channel compare shadow write strobe |
| cmp_wr_data | input | 16 | Compare value to write |
| act_wr_en | input | 1 | Action-word shadow write strobe |
| act_wr_data | input | 12 | Action word, 2 bits per pin |
| db_en | input | 3 | Per-channel dead-time enable |
| db_val | input | 8 | Shared dead-time value D |
| db_div_sel | input | 3 | Dead-time prescaler select, divide by 2^s |
| out_en | input | 1 | Global output enable |
| pwm_pin | output | 6 | Pin drives; 2c high side, 2c+1 low side |

## Verification
The dead-time assertions assume that the shared dead-time value and the divider select stay constant while any channel's dead-time window is open. Otherwise the bound relating a channel's counter to the value would not hold. The bench changes both settings only after every channel has settled with its window closed. It drives the timer count on falling edges as a directed sequence of steady values and zero pulses, rather than a free-running ramp, so each transition lands on a known edge.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
  typedef enum logic [1:0] {
    ACT_FORCE_LO = 2'b00,
    ACT_INVERT   = 2'b01,
    ACT_DIRECT   = 2'b10,
    ACT_FORCE_HI = 2'b11
  } act_code_e;

  function automatic logic act_apply(input logic [1:0] code, input logic s);
    case (act_code_e'(code))
      ACT_FORCE_LO: act_apply = 1'b0;
      ACT_INVERT:   act_apply = ~s;
      ACT_DIRECT:   act_apply = s;
      default:      act_apply = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pwm3_shadow_reg.sv
`timescale 1ns/1ps
module pwm3_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr_en) shadow <= wr_data;
      if (load)  active <= shadow;
    end
  end

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> active == $past(shadow)); // R2
endmodule

// File: rtl/pwm3_prescale.sv
`timescale 1ns/1ps
module pwm3_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pre_cnt;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(div_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + PC_W'(1);
  end

  assign tick = &(pre_cnt | ~mask);
endmodule

// File: rtl/pwm3_db_channel.sv
`timescale 1ns/1ps
module pwm3_db_channel #(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             load,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_data,
  input  logic             db_en,
  input  logic [DB_W-1:0]  db_val,
  output logic             dead_hi,
  output logic             dead_lo
);
  logic [CNT_W-1:0] cmp_sh, cmp_act, cmp_eff;
  logic             raw_next, raw_r, chg, hold;
  logic [DB_W-1:0]  dt_cnt;

  pwm3_shadow_reg #(.W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_wr), .wr_data(cmp_data),
    .load(load), .shadow(cmp_sh), .active(cmp_act)
  );

  assign cmp_eff  = load ? cmp_sh : cmp_act;
  assign raw_next = (tmr_cnt < cmp_eff);
  assign chg      = (raw_next != raw_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_r  <= 1'b0;
      hold   <= 1'b0;
      dt_cnt <= '0;
    end else begin
      raw_r <= raw_next;
      if (!db_en) begin
        hold   <= 1'b0;
        dt_cnt <= '0;
      end else if (chg) begin
        hold   <= 1'b1;
        dt_cnt <= '0;
      end else if (hold) begin
        if (dt_cnt >= db_val) hold <= 1'b0;
        else if (tick)        dt_cnt <= dt_cnt + DB_W'(1);
      end
    end
  end

  assign dead_hi = raw_r & ~hold;
  assign dead_lo = ~raw_r & ~hold;

  AST_EDGE_BLANKS: assert property (@(posedge clk) disable iff (rst)
    db_en && chg |=> !dead_hi && !dead_lo); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold |-> dt_cnt <= db_val); // R7
  AST_NO_DB_GAP: assert property (@(posedge clk) disable iff (rst)
    $past(!db_en) |-> dead_hi != dead_lo); // R6
endmodule

// File: rtl/pwm3_out_stage.sv
`timescale 1ns/1ps
module pwm3_out_stage
  import pwm3_pkg::*;
#(
  parameter int N_PIN = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               out_en,
  input  logic [2*N_PIN-1:0] act_word,
  input  logic [N_PIN-1:0]   sig,
  output logic [N_PIN-1:0]   pins
);
  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)         pins[p] <= 1'b0;
      else if (!out_en) pins[p] <= 1'b0;
      else             pins[p] <= act_apply(act_word[2*p +: 2], sig[p]);
    end
  end

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> pins == '0); // R9
endmodule

// File: rtl/pwm3_db_stage.sv
`timescale 1ns/1ps
module pwm3_db_stage #(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8,
  parameter int SEL_W = 3,
  parameter int N_CH  = 3,
  localparam int N_PIN = 2 * N_CH,
  localparam int ACT_W = 2 * N_PIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic [N_CH-1:0]  cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             act_wr_en,
  input  logic [ACT_W-1:0] act_wr_data,
  input  logic [N_CH-1:0]  db_en,
  input  logic [DB_W-1:0]  db_val,
  input  logic [SEL_W-1:0] db_div_sel,
  input  logic             out_en,
  output logic [N_PIN-1:0] pwm_pin
);
  logic             load, tick;
  logic [ACT_W-1:0] act_sh, act_act;
  logic [N_PIN-1:0] pair_sig;

  assign load = (tmr_cnt == '0);

  pwm3_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .div_sel(db_div_sel), .tick(tick)
  );

  pwm3_shadow_reg #(.W(ACT_W)) u_act (
    .clk(clk), .rst(rst), .wr_en(act_wr_en), .wr_data(act_wr_data),
    .load(load), .shadow(act_sh), .active(act_act)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm3_db_channel #(.CNT_W(CNT_W), .DB_W(DB_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .tmr_cnt(tmr_cnt), .load(load),
      .cmp_wr(cmp_wr_en[c]), .cmp_data(cmp_wr_data),
      .db_en(db_en[c]), .db_val(db_val),
      .dead_hi(pair_sig[2*c]), .dead_lo(pair_sig[2*c+1])
    );
  end

  pwm3_out_stage #(.N_PIN(N_PIN)) u_out (
    .clk(clk), .rst(rst), .out_en(out_en), .act_word(act_act),
    .sig(pair_sig), .pins(pwm_pin)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> pwm_pin == '0); // R10
endmodule

// File: tb/pwm3_db_stage_tb.sv
`timescale 1ns/1ps
module pwm3_db_stage_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] tmr_cnt;
  logic [2:0]  cmp_wr_en;
  logic [15:0] cmp_wr_data;
  logic        act_wr_en;
  logic [11:0] act_wr_data;
  logic [2:0]  db_en;
  logic [7:0]  db_val;
  logic [2:0]  db_div_sel;
  logic        out_en;
  logic [5:0]  pwm_pin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm3_db_stage u_dut (
    .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .cmp_wr_en(cmp_wr_en),
    .cmp_wr_data(cmp_wr_data), .act_wr_en(act_wr_en), .act_wr_data(act_wr_data),
    .db_en(db_en), .db_val(db_val), .db_div_sel(db_div_sel),
    .out_en(out_en), .pwm_pin(pwm_pin)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input int ch, input logic [15:0] v);
    @(negedge clk);
    cmp_wr_en = 3'(1 << ch);
    cmp_wr_data = v;
    @(negedge clk);
    cmp_wr_en = '0;
  endtask

  task automatic wr_act(input logic [11:0] w);
    @(negedge clk);
    act_wr_en = 1'b1;
    act_wr_data = w;
    @(negedge clk);
    act_wr_en = 1'b0;
  endtask

  task automatic zero_pulse(input logic [15:0] after_v);
    @(negedge clk);
    tmr_cnt = 16'd0;
    @(negedge clk);
    tmr_cnt = after_v;
  endtask

  // drive a new count, count samples with both ch0 pins low until pin 'watch' rises
  task automatic measure(input logic [15:0] newv, input int watch, output int zeros);
    @(negedge clk);
    tmr_cnt = newv;
    zeros = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pwm_pin[watch]) break;
      if (pwm_pin[1:0] == 2'b00) zeros++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 pins low in reset", int'(pwm_pin), 0);
    rst = 1'b0;
  endtask

  task automatic t_shadow_cmp();
    db_en = 3'b000;
    wr_cmp(0, 16'd10);
    wr_cmp(1, 16'd3);
    wr_cmp(2, 16'd0);
    wr_act(12'hAAA);
    settle(4);
    chk("R4 action shadow idle before zero", int'(pwm_pin), 0);
    zero_pulse(16'd5);
    settle(4);
    chk("R2 compare load at zero", int'(pwm_pin), 6'b101001);
    wr_cmp(1, 16'd8);
    settle(4);
    chk("R2 compare shadow held", int'(pwm_pin), 6'b101001);
    zero_pulse(16'd5);
    settle(4);
    chk("R2 new compare active", int'(pwm_pin), 6'b100101);
  endtask

  task automatic t_compare();
    @(negedge clk); tmr_cnt = 16'd9;
    settle(4);
    chk("R1 count 9", int'(pwm_pin), 6'b101001);
    @(negedge clk); tmr_cnt = 16'd2;
    @(negedge clk);
    chk("R1 one edge: not yet", int'(pwm_pin), 6'b101001);
    @(negedge clk);
    chk("R1 two edges: updated", int'(pwm_pin), 6'b100101);
    @(negedge clk); tmr_cnt = 16'd10;
    settle(4);
    chk("R1 count equals compare", int'(pwm_pin), 6'b101010);
    @(negedge clk); tmr_cnt = 16'd5;
    settle(4);
    chk("R1 count 5", int'(pwm_pin), 6'b100101);
  endtask

  task automatic t_action();
    @(negedge clk); tmr_cnt = 16'd2;
    settle(4);
    wr_act(12'h79C);
    settle(4);
    chk("R4 action change waits for zero", int'(pwm_pin), 6'b100101);
    zero_pulse(16'd2);
    settle(4);
    chk("R3 action codes", int'(pwm_pin), 6'b010010);
    wr_act(12'hAAA);
    zero_pulse(16'd5);
    settle(4);
  endtask

  task automatic t_nodb();
    int z;
    db_en = 3'b000;
    measure(16'd20, 1, z);
    chk("R6 no dead cycles when disabled", z, 0);
    @(negedge clk); tmr_cnt = 16'd5;
    settle(4);
  endtask

  task automatic t_db();
    int z;
    db_en = 3'b111;
    db_val = 8'd4;
    db_div_sel = 3'd0;
    settle(4);
    measure(16'd20, 1, z);
    chk("R5 dead time falling", z, 5);
    measure(16'd5, 0, z);
    chk("R5 dead time rising", z, 5);
    settle(8);
  endtask

  task automatic t_restart();
    int z;
    bit lo_seen;
    z = 0;
    lo_seen = 1'b0;
    @(negedge clk); tmr_cnt = 16'd20;
    @(negedge clk);
    @(negedge clk);
    if (pwm_pin[1:0] == 2'b00) z++;
    tmr_cnt = 16'd5;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pwm_pin[1]) lo_seen = 1'b1;
      if (pwm_pin[0]) break;
      if (pwm_pin[1:0] == 2'b00) z++;
    end
    chk("R7 restarted dead window", z, 7);
    chk("R7 low side never driven", int'(lo_seen), 0);
    settle(8);
  endtask

  task automatic t_presc();
    int z;
    db_val = 8'd3;
    db_div_sel = 3'd2;
    settle(2);
    measure(16'd20, 1, z);
    chk_range("R8 prescaled dead time", z, 10, 13);
    @(negedge clk); tmr_cnt = 16'd5;
    settle(40);
  endtask

  task automatic t_outen();
    chk("R9 pins before disable", int'(pwm_pin), 6'b100101);
    @(negedge clk); out_en = 1'b0;
    @(negedge clk);
    chk("R9 pins low after disable", int'(pwm_pin), 0);
    settle(3);
    out_en = 1'b1;
    @(negedge clk);
    chk("R9 pins restored", int'(pwm_pin), 6'b100101);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    tmr_cnt = 16'd5;
    cmp_wr_en = '0;
    cmp_wr_data = '0;
    act_wr_en = 1'b0;
    act_wr_data = '0;
    db_en = '0;
    db_val = '0;
    db_div_sel = '0;
    out_en = 1'b1;
    settle(3);
    t_reset();
    t_shadow_cmp();
    t_compare();
    t_action();
    t_nodb();
    t_db();
    t_restart();
    t_presc();
    t_outen();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule